// File: doc/BRIEF.md
# Weekly Minute Alarm Comparator

This block holds an alarm made of a BCD minute, a BCD hour and a set of weekdays. It compares that alarm against the running time of a calendar counter. The calendar counter supplies its current minute, hour and weekday number. It also supplies a strobe that pulses once each time the seconds count wraps to zero. The comparison is made only on that strobe. When the alarm matches and the alarm enable is set, a pending flag is latched and drives a level interrupt.

Software reaches the alarm fields, the enable and the pending flag through a simple register bus. Writes take effect at a clock edge and read data is combinational from the address. The weekday is chosen by a bitmask rather than a date. A single alarm can therefore cover any mix of days, but it can never lie more than one week ahead, and its resolution is one minute.

Top module: `wkalarm_top`

## Requirements
- R1: After reset the alarm minute, alarm hour, weekday mask, enable and pending flag are all zero, and `irq` is low.
- R2: The register map is as follows. Alarm minute is at 0x40, bits [6:0]. Alarm hour is at 0x44, bits [5:0]. Weekday mask is at 0x48, bits [6:0]. Control is at 0x04, with the enable in bit 4. Status is at 0x0C, with the pending flag in bit 0. Unused bits and unmapped addresses read as zero.
- R3: On a cycle with `min_tick` high, the pending flag and `irq` rise in the following cycle when all of these hold: the enable is set, `cur_min` equals the alarm minute, `cur_hour` equals the alarm hour, and the mask bit numbered `cur_wday` is set.
- R4: Without `min_tick`, equal time values never set the pending flag.
- R5: Bit n of the weekday mask selects weekday n, for n from 0 to 6. Several bits may be set at once. A weekday whose bit is clear does not match. The weekday value 7 never matches.
- R6: A difference in minute or in hour prevents a match.
- R7: The pending flag stays set until a write to status with bit 0 at one clears it. A status write with bit 0 at zero leaves it set.
- R8: Writing zero to control clears the enable. This masks `irq` from the next cycle on while the pending flag remains readable, and setting the enable again brings `irq` back.
- R9: A match that occurs while the enable is clear does not set the pending flag.
- R10: When a match and a clearing status write fall in the same cycle, the pending flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_wday | input | 3 | Current weekday number |
| min_tick | input | 1 | One-cycle strobe at each minute boundary |
| irq | output | 1 | Level alarm interrupt |

## Verification
The bench builds the block with its default parameters: seven-bit minute, six-bit hour, seven weekdays, a three-bit weekday input and a combinational match path. With these values the BCD extremes 59 and 23 can be reached. The three-bit weekday input can also carry the value 7, which lies outside the mask, so the rejection of out-of-range days can be tested. The single-cycle match path gives exactly one cycle between the strobe and the interrupt, and the bench checks that cycle exactly.

// File: rtl/wka_pkg.sv
package wka_pkg;
   // Offsets kept because the driving software decodes them
   localparam int unsigned OFS_CTRL  = 32'h04;
   localparam int unsigned OFS_STAT  = 32'h0C;
   localparam int unsigned OFS_AMIN  = 32'h40;
   localparam int unsigned OFS_AHOUR = 32'h44;
   localparam int unsigned OFS_AWDAY = 32'h48;
   localparam int unsigned EN_BIT    = 4;
   localparam int unsigned PEND_BIT  = 0;
endpackage

// File: rtl/wka_regs.sv
module wka_regs
   import wka_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int MIN_BITS  = 7,
   parameter int HOUR_BITS = 6,
   parameter int DAYS      = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   input  logic                 pend_i,
   output logic [DATA_W-1:0]    rdata,
   output logic [MIN_BITS-1:0]  alm_min,
   output logic [HOUR_BITS-1:0] alm_hour,
   output logic [DAYS-1:0]      alm_days,
   output logic                 en,
   output logic                 clr
);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_AMIN  = ADDR_W'(OFS_AMIN);
   localparam logic [ADDR_W-1:0] A_AHOUR = ADDR_W'(OFS_AHOUR);
   localparam logic [ADDR_W-1:0] A_AWDAY = ADDR_W'(OFS_AWDAY);

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alm_min  <= '0;
         alm_hour <= '0;
         alm_days <= '0;
         en       <= 1'b0;
      end else if (we) begin
         case (addr)
            A_AMIN:  alm_min  <= wdata[MIN_BITS-1:0];
            A_AHOUR: alm_hour <= wdata[HOUR_BITS-1:0];
            A_AWDAY: alm_days <= wdata[DAYS-1:0];
            A_CTRL:  en       <= wdata[EN_BIT];
            default: ;
         endcase
      end
   end

   assign clr = we && (addr == A_STAT) && wdata[PEND_BIT];

   always_comb begin
      rdata = '0;
      case (addr)
         A_AMIN:  rdata[MIN_BITS-1:0]  = alm_min;
         A_AHOUR: rdata[HOUR_BITS-1:0] = alm_hour;
         A_AWDAY: rdata[DAYS-1:0]      = alm_days;
         A_CTRL:  rdata[EN_BIT]        = en;
         A_STAT:  rdata[PEND_BIT]      = pend_i;
         default: ;
      endcase
   end
endmodule

// File: rtl/wka_match.sv
module wka_match #(
   parameter int MIN_BITS  = 7,
   parameter int HOUR_BITS = 6,
   parameter int DAYS      = 7,
   parameter int WDAY_W    = 3,
   parameter bit MATCH_REG = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic [MIN_BITS-1:0]  cur_min,
   input  logic [HOUR_BITS-1:0] cur_hour,
   input  logic [WDAY_W-1:0]    cur_wday,
   input  logic [MIN_BITS-1:0]  alm_min,
   input  logic [HOUR_BITS-1:0] alm_hour,
   input  logic [DAYS-1:0]      alm_days,
   output logic                 hit_tick
);
   logic [DAYS-1:0] day_hit;
   logic            hit_c;

   for (genvar d = 0; d < DAYS; d++) begin : g_day
      assign day_hit[d] = alm_days[d] && (cur_wday == WDAY_W'(d));
   end

   assign hit_c = tick && (cur_min == alm_min) && (cur_hour == alm_hour) && (|day_hit);

   if (MATCH_REG) begin : g_reg
      logic hit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hit_q <= 1'b0;
         else        hit_q <= hit_c;
      end
      assign hit_tick = hit_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign hit_tick   = hit_c;
   end
endmodule

// File: rtl/wka_pend.sv
module wka_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic en,
   output logic pend,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend <= 1'b0;
      else if (set && en)  pend <= 1'b1;
      else if (clr)        pend <= 1'b0;
   end

   assign irq = pend && en;
endmodule

// File: rtl/wkalarm_top.sv
module wkalarm_top #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int MIN_BITS  = 7,
   parameter int HOUR_BITS = 6,
   parameter int DAYS      = 7,
   parameter int WDAY_W    = 3,
   parameter bit MATCH_REG = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [MIN_BITS-1:0]  cur_min,
   input  logic [HOUR_BITS-1:0] cur_hour,
   input  logic [WDAY_W-1:0]    cur_wday,
   input  logic                 min_tick,
   output logic                 irq
);
   localparam int MAX_OFS = 'h48;

   if (MIN_BITS < 7)                    begin : g_bad_min  $error("MIN_BITS must hold BCD 59");  end
   if (HOUR_BITS < 6)                   begin : g_bad_hour $error("HOUR_BITS must hold BCD 23"); end
   if (DAYS < 1 || DAYS > (1 << WDAY_W)) begin : g_bad_day $error("DAYS must fit WDAY_W");      end
   if (DATA_W < 8 || DATA_W < DAYS)     begin : g_bad_data $error("DATA_W too narrow");          end
   if ((1 << ADDR_W) <= MAX_OFS)        begin : g_bad_addr $error("ADDR_W too narrow");          end

   logic [MIN_BITS-1:0]  alm_min_w;
   logic [HOUR_BITS-1:0] alm_hour_w;
   logic [DAYS-1:0]      alm_days_w;
   logic                 en_w;
   logic                 clr_w;
   logic                 pend_w;
   logic                 hit_tick_w;

   wka_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_BITS(MIN_BITS),
      .HOUR_BITS(HOUR_BITS), .DAYS(DAYS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .pend_i(pend_w), .rdata(bus_rdata), .alm_min(alm_min_w), .alm_hour(alm_hour_w),
      .alm_days(alm_days_w), .en(en_w), .clr(clr_w)
   );

   wka_match #(
      .MIN_BITS(MIN_BITS), .HOUR_BITS(HOUR_BITS), .DAYS(DAYS),
      .WDAY_W(WDAY_W), .MATCH_REG(MATCH_REG)
   ) u_match (
      .clk(clk), .rst_n(rst_n), .tick(min_tick), .cur_min(cur_min), .cur_hour(cur_hour),
      .cur_wday(cur_wday), .alm_min(alm_min_w), .alm_hour(alm_hour_w),
      .alm_days(alm_days_w), .hit_tick(hit_tick_w)
   );

   wka_pend u_pend (
      .clk(clk), .rst_n(rst_n), .set(hit_tick_w), .clr(clr_w), .en(en_w),
      .pend(pend_w), .irq(irq)
   );
endmodule

// File: rtl/wka_chk.sv
module wka_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              hit_tick,
   input logic              en_q,
   input logic              pend_q,
   input logic              irq
);
   logic stat_clr;
   assign stat_clr = bus_we && (bus_addr == ADDR_W'(wka_pkg::OFS_STAT)) && bus_wdata[0];

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !irq); // R8

   AST_NO_SET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(en_q)); // R9

   AST_SET_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(hit_tick)); // R4

   AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_tick && en_q) |=> pend_q); // R3

   AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !stat_clr) |=> pend_q); // R7
endmodule

bind wkalarm_top wka_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .hit_tick(hit_tick_w), .en_q(en_w),
   .pend_q(pend_w), .irq(irq)
);

// File: tb/test_wkalarm_top.sv
`timescale 1ns/1ps
module test_wkalarm_top;
   typedef struct packed {
      logic [7:0] amin;
      logic [7:0] ahr;
      logic [7:0] mask;
      logic [7:0] cmin;
      logic [7:0] chr;
      logic [2:0] wd;
      logic       exp;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{8'h30, 8'h12, 8'h04, 8'h30, 8'h12, 3'd2, 1'b1},
      '{8'h30, 8'h12, 8'h04, 8'h30, 8'h12, 3'd3, 1'b0},
      '{8'h30, 8'h12, 8'h7F, 8'h30, 8'h12, 3'd6, 1'b1},
      '{8'h59, 8'h23, 8'h41, 8'h59, 8'h23, 3'd0, 1'b1},
      '{8'h59, 8'h23, 8'h41, 8'h58, 8'h23, 3'd0, 1'b0},
      '{8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 3'd0, 1'b0},
      '{8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 3'd0, 1'b1},
      '{8'h45, 8'h09, 8'h00, 8'h45, 8'h09, 3'd3, 1'b0},
      '{8'h45, 8'h09, 8'h7F, 8'h45, 8'h09, 3'd7, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [6:0]  cur_min = '0;
   logic [5:0]  cur_hour = '0;
   logic [2:0]  cur_wday = '0;
   logic        min_tick = 1'b0;
   logic        irq;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   wkalarm_top i_wkalarm_top (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cur_min(cur_min),
      .cur_hour(cur_hour), .cur_wday(cur_wday), .min_tick(min_tick), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic tick(input logic [6:0] m, input logic [5:0] h, input logic [2:0] w);
      @(negedge clk);
      cur_min = m; cur_hour = h; cur_wday = w; min_tick = 1'b1;
      @(negedge clk);
      min_tick = 1'b0;
   endtask

   task automatic arm(input logic [6:0] m, input logic [5:0] h, input logic [6:0] mask);
      wr(8'h40, 32'(m));
      wr(8'h44, 32'(h));
      wr(8'h48, 32'(mask));
      wr(8'h04, 32'h10);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end

   initial begin
      logic [31:0] d;
      #1;
      // R1: reset state
      check("R1 irq in reset", 32'(irq), 32'h0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 irq after reset", 32'(irq), 32'h0);
      rd(8'h40, d); check("R1 alarm minute", d, 32'h0);
      rd(8'h44, d); check("R1 alarm hour", d, 32'h0);
      rd(8'h48, d); check("R1 weekday mask", d, 32'h0);
      rd(8'h04, d); check("R1 control", d, 32'h0);
      rd(8'h0C, d); check("R1 status", d, 32'h0);

      // R2: field widths and map
      wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, d); check("R2 minute field", d, 32'h7F);
      wr(8'h44, 32'hFFFF_FFFF); rd(8'h44, d); check("R2 hour field", d, 32'h3F);
      wr(8'h48, 32'hFFFF_FFFF); rd(8'h48, d); check("R2 weekday field", d, 32'h7F);
      wr(8'h04, 32'hFFFF_FFEF); rd(8'h04, d); check("R2 control enable clear", d, 32'h0);
      wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d); check("R2 control enable bit4", d, 32'h10);
      wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, d); check("R2 unmapped reads zero", d, 32'h0);
      wr(8'h04, 32'h0);

      // Vector table: R3, R5, R6
      for (int i = 0; i < NV; i++) begin
         arm(VECS[i].amin[6:0], VECS[i].ahr[5:0], VECS[i].mask[6:0]);
         tick(VECS[i].cmin[6:0], VECS[i].chr[5:0], VECS[i].wd);
         check($sformatf("R3 R5 R6 vector %0d irq", i), 32'(irq), 32'(VECS[i].exp));
         rd(8'h0C, d);
         check($sformatf("R3 R5 R6 vector %0d status", i), d, 32'(VECS[i].exp));
         wr(8'h0C, 32'h1);
         check($sformatf("R7 vector %0d cleared", i), 32'(irq), 32'h0);
      end

      // R4: equal values held without a strobe
      arm(7'h15, 6'h08, 7'h08);
      @(negedge clk);
      cur_min = 7'h15; cur_hour = 6'h08; cur_wday = 3'd3;
      repeat (5) @(negedge clk);
      check("R4 no strobe irq", 32'(irq), 32'h0);
      rd(8'h0C, d); check("R4 no strobe status", d, 32'h0);

      // R7: hold until W1C
      tick(7'h15, 6'h08, 3'd3);
      wr(8'h0C, 32'h0);
      check("R7 zero write keeps irq", 32'(irq), 32'h1);
      rd(8'h0C, d); check("R7 zero write keeps status", d, 32'h1);
      repeat (4) @(negedge clk);
      check("R7 level held", 32'(irq), 32'h1);
      wr(8'h0C, 32'h1);
      rd(8'h0C, d); check("R7 one write clears", d, 32'h0);

      // R8: masking by control write of zero
      tick(7'h15, 6'h08, 3'd3);
      check("R8 pending before mask", 32'(irq), 32'h1);
      wr(8'h04, 32'h0);
      check("R8 irq masked", 32'(irq), 32'h0);
      rd(8'h0C, d); check("R8 pending still visible", d, 32'h1);
      wr(8'h04, 32'h10);
      check("R8 irq returns", 32'(irq), 32'h1);
      wr(8'h0C, 32'h1);

      // R9: match while disabled
      wr(8'h04, 32'h0);
      tick(7'h15, 6'h08, 3'd3);
      rd(8'h0C, d); check("R9 disabled match status", d, 32'h0);
      wr(8'h04, 32'h10);
      check("R9 enable after missed match", 32'(irq), 32'h0);

      // R10: match and clear in the same cycle
      @(negedge clk);
      cur_min = 7'h15; cur_hour = 6'h08; cur_wday = 3'd3; min_tick = 1'b1;
      bus_we = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h1;
      @(negedge clk);
      min_tick = 1'b0; bus_we = 1'b0;
      check("R10 set wins irq", 32'(irq), 32'h1);
      rd(8'h0C, d); check("R10 set wins status", d, 32'h1);

      done = 1'b1;
      finish_run();
   end
endmodule